// File: doc/BRIEF.md
# Double-Buffered DAC Code Interface

This block is the digital front end of a 12-bit parallel-input converter. A host writes a code into an input register, which has two sections: an 8-bit low byte and a 4-bit high nibble. Each section has its own active-low select. Both sections share one active-low write strobe. A separate active-low load strobe then moves the complete 12-bit input code into a DAC holding register. That register drives the code output and a tap index for the resistor string.

The host strobes are asynchronous to the system clock. Each one passes through a two-stage synchronizer. The data lines pass through a pipeline of the same depth, so data stays aligned with its strobes. An enabled input section follows its data on every clock cycle while the strobe and its select are low. When the write strobe rises, the section keeps the value it last captured. The DAC register behaves the same way: it follows the input register while the load strobe is low, and it takes one final copy when the load strobe rises.

The high-nibble data lines can be wired to the lowest four low-byte lines. An 8-bit bus then fills the 12-bit code in two write cycles. An asynchronous active-low clear zeroes both registers and overrides every other input.

Top module: `dac_bus_front`

## Requirements
- R1: A low on `clr_n` forces the code output to 0x000 without waiting for a clock edge. While `clr_n` is low, `upd_pulse` is 0.
- R2: With the write strobe and the low-byte select both low, code bits [7:0] take `d_lo` after the next load. Bits [11:8] stay unchanged.
- R3: With the write strobe and the high-nibble select both low, code bits [11:8] take `d_hi` after the next load. Bits [7:0] stay unchanged.
- R4: With both selects low during one write, all 12 bits load at once as {`d_hi`, `d_lo`}.
- R5: While the write strobe and a select are held low, that section follows changes on its data lines.
- R6: After the write strobe rises, later data changes have no effect on the section, even if its select is still low.
- R7: A low write strobe with both selects high leaves the input register unchanged.
- R8: While the load strobe stays high, the code output does not change. When the load strobe rises, the code output takes the full input register.
- R9: While the load strobe is held low, the code output follows the input register, one clock cycle behind it.
- R10: While `clr_n` is low, write and load activity changes neither register. After `clr_n` is released with all strobes high, the code output stays at 0x000.
- R11: `tap_idx` always equals the code output. Code 0x000 selects the bottom tap and code 0xFFF selects the top tap minus one LSB.
- R12: `upd_pulse` is high for exactly one cycle, in the cycle where the code output first shows a new value. It stays low when a load does not change the value.
- R13: With `d_hi` driven from `d_lo[3:0]`, two successive writes load an 8-bit-bus code. The first write uses the low-byte select and the second uses the high-nibble select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_lo_n | input | 1 | Low-byte select, active low |
| cs_hi_n | input | 1 | High-nibble select, active low |
| ld_n | input | 1 | Load strobe to the DAC register, active low |
| d_lo | input | 8 | Low-byte data |
| d_hi | input | 4 | High-nibble data |
| dac_code | output | 12 | DAC holding register value |
| tap_idx | output | 12 | Resistor-string tap index |
| upd_pulse | output | 1 | One-cycle pulse when `dac_code` changes |

## Verification
The assertions assume the following about the inputs:
- Every strobe level is held for more cycles than the synchronizer depth, so no edge is lost in the synchronizer.
- Clear lasts at least one full clock cycle.
- The strobes are already high when clear is released.

The bench stays within these limits. Each strobe level is held for four cycles, and data only changes at falling clock edges, away from any strobe transition. The one-cycle lag of the DAC register behind the input register is checked against the synchronized load strobe.

// File: rtl/dac_bus_pkg.sv
package dac_bus_pkg;
    localparam int unsigned CODE_W_DEF = 12;
    localparam int unsigned LO_W_DEF   = 8;
    localparam int unsigned SYNC_DEF   = 2;

    typedef struct packed {
        logic wr_n;
        logic cs_lo_n;
        logic cs_hi_n;
        logic ld_n;
    } strobe_t;

    localparam int unsigned STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int unsigned       W      = 1,
    parameter int unsigned       STAGES = 2,
    parameter logic [W-1:0]      RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= RST;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/dac_input_stage.sv
module dac_input_stage #(
    parameter int unsigned LO_W = 8,
    parameter int unsigned HI_W = 4,
    localparam int unsigned CW  = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_n_s,
    input  logic            cs_lo_n_s,
    input  logic            cs_hi_n_s,
    input  logic [LO_W-1:0] d_lo_s,
    input  logic [HI_W-1:0] d_hi_s,
    output logic [CW-1:0]   in_code
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } inreg_t;

    inreg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!wr_n_s && !cs_lo_n_s) begin
            r_d.lo = d_lo_s;
        end
        if (!wr_n_s && !cs_hi_n_s) begin
            r_d.hi = d_hi_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_code = r_q;
endmodule

// File: rtl/dac_hold_stage.sv
module dac_hold_stage #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n_s,
    input  logic [CW-1:0] in_code,
    output logic [CW-1:0] code,
    output logic          upd
);
    typedef struct packed {
        logic [CW-1:0] code;
        logic          ld_prev;
        logic          upd;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d         = h_q;
        h_d.ld_prev = ld_n_s;
        // transparent while low, final copy on the rising edge
        if (!ld_n_s || !h_q.ld_prev) begin
            h_d.code = in_code;
        end
        h_d.upd = (h_d.code != h_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.code    <= '0;
            h_q.ld_prev <= 1'b1;
            h_q.upd     <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign code = h_q.code;
    assign upd  = h_q.upd;
endmodule

// File: rtl/dac_bus_front.sv
module dac_bus_front
    import dac_bus_pkg::*;
#(
    parameter int unsigned CODE_W      = CODE_W_DEF,
    parameter int unsigned LO_W        = LO_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF,
    localparam int unsigned HI_W       = CODE_W - LO_W
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_n,
    input  logic              cs_lo_n,
    input  logic              cs_hi_n,
    input  logic              ld_n,
    input  logic [LO_W-1:0]   d_lo,
    input  logic [HI_W-1:0]   d_hi,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] tap_idx,
    output logic              upd_pulse
);
    strobe_t           strb_raw, strb_s;
    logic [CODE_W-1:0] data_s;
    logic [CODE_W-1:0] in_code;
    logic              wr_s, cs_lo_s, cs_hi_s, ld_s;

    assign strb_raw = '{wr_n: wr_n, cs_lo_n: cs_lo_n, cs_hi_n: cs_hi_n, ld_n: ld_n};

    dac_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST({STROBE_W{1'b1}})) u_strb_sync (
        .clk   (clk),
        .rst_n (clr_n),
        .din   (strb_raw),
        .dout  (strb_s)
    );

    // data delayed by the same depth so it stays aligned with its strobes
    dac_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST('0)) u_data_sync (
        .clk   (clk),
        .rst_n (clr_n),
        .din   ({d_hi, d_lo}),
        .dout  (data_s)
    );

    assign wr_s    = strb_s.wr_n;
    assign cs_lo_s = strb_s.cs_lo_n;
    assign cs_hi_s = strb_s.cs_hi_n;
    assign ld_s    = strb_s.ld_n;

    dac_input_stage #(.LO_W(LO_W), .HI_W(HI_W)) u_in (
        .clk       (clk),
        .rst_n     (clr_n),
        .wr_n_s    (wr_s),
        .cs_lo_n_s (cs_lo_s),
        .cs_hi_n_s (cs_hi_s),
        .d_lo_s    (data_s[LO_W-1:0]),
        .d_hi_s    (data_s[CODE_W-1:LO_W]),
        .in_code   (in_code)
    );

    dac_hold_stage #(.CW(CODE_W)) u_hold (
        .clk     (clk),
        .rst_n   (clr_n),
        .ld_n_s  (ld_s),
        .in_code (in_code),
        .code    (dac_code),
        .upd     (upd_pulse)
    );

    assign tap_idx = dac_code;
endmodule

// File: rtl/dac_bus_front_chk.sv
module dac_bus_front_chk #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned LO_W   = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              wr_s,
    input logic              cs_lo_s,
    input logic              ld_s,
    input logic [CODE_W-1:0] in_code,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] tap_idx,
    input logic              upd_pulse
);
    always @(negedge clk) begin
        if (clr_n === 1'b0) begin
            a_r1_clear_zero: assert (dac_code == '0 && !upd_pulse)
                else $error("R1: output not cleared");
        end
    end

    a_r11_tap_equals_code: assert property (@(posedge clk) disable iff (!clr_n)
        tap_idx == dac_code) else $error("R11: tap mismatch");

    a_r12_pulse_has_change: assert property (@(posedge clk) disable iff (!clr_n)
        upd_pulse |-> dac_code != $past(dac_code)) else $error("R12: spurious pulse");

    a_r12_change_has_pulse: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && dac_code != $past(dac_code)) |-> upd_pulse)
        else $error("R12: missing pulse");

    a_r9_transparent_load: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_s |=> dac_code == $past(in_code)) else $error("R9: not transparent");

    a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_s && $past(ld_s)) |=> $stable(dac_code)) else $error("R8: changed without load");

    a_r7_lo_hold_unselected: assert property (@(posedge clk) disable iff (!clr_n)
        (wr_s || cs_lo_s) |=> $stable(in_code[LO_W-1:0])) else $error("R7: low byte moved");
endmodule

bind dac_bus_front dac_bus_front_chk #(.CODE_W(CODE_W), .LO_W(LO_W)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .wr_s      (wr_s),
    .cs_lo_s   (cs_lo_s),
    .ld_s      (ld_s),
    .in_code   (in_code),
    .dac_code  (dac_code),
    .tap_idx   (tap_idx),
    .upd_pulse (upd_pulse)
);

// File: tb/test_dac_bus_front.sv
module test_dac_bus_front;
    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        wr_n = 1'b1, cs_lo_n = 1'b1, cs_hi_n = 1'b1, ld_n = 1'b1;
    logic [7:0]  d_lo = '0;
    logic [3:0]  d_hi = '0;
    logic [11:0] dac_code, tap_idx;
    logic        upd_pulse;
    int          checks = 0, errors = 0, pulses = 0;

    always #4 clk = ~clk;

    dac_bus_front i_dac_bus_front (
        .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
        .ld_n(ld_n), .d_lo(d_lo), .d_hi(d_hi), .dac_code(dac_code),
        .tap_idx(tap_idx), .upd_pulse(upd_pulse)
    );

    always @(negedge clk) if (upd_pulse) pulses++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] lo, input logic [3:0] hi,
                             input logic sel_lo, input logic sel_hi);
        d_lo = lo; d_hi = hi; cs_lo_n = !sel_lo; cs_hi_n = !sel_hi;
        step(1); wr_n = 1'b0;
        step(4); wr_n = 1'b1;
        step(4); cs_lo_n = 1'b1; cs_hi_n = 1'b1;
        step(1);
    endtask

    task automatic load_pulse();
        ld_n = 1'b0; step(4);
        ld_n = 1'b1; step(4);
    endtask

    task automatic t_reset();
        step(3);
        check("R1 code in clear", dac_code, 12'h000);
        check("R1 pulse in clear", upd_pulse, 0);
        clr_n = 1'b1; step(4);
        check("R11 tap at zero", tap_idx, 12'h000);
    endtask

    task automatic t_full_word();
        bus_write(8'h5C, 4'hA, 1, 1);
        pulses = 0; load_pulse();
        check("R4 full word", dac_code, 12'hA5C);
        check("R11 tap follows", tap_idx, 12'hA5C);
        check("R12 one pulse", pulses, 1);
        pulses = 0; load_pulse();
        check("R12 no pulse on same", pulses, 0);
    endtask

    task automatic t_sections();
        bus_write(8'h3E, 4'hF, 1, 0); load_pulse();
        check("R2 low byte only", dac_code, 12'hA3E);
        bus_write(8'hFF, 4'h7, 0, 1); load_pulse();
        check("R3 high nibble only", dac_code, 12'h73E);
        bus_write(8'h00, 4'h0, 0, 0); load_pulse();
        check("R7 no select ignored", dac_code, 12'h73E);
    endtask

    task automatic t_load_gate();
        bus_write(8'h11, 4'h1, 1, 1);
        step(4);
        check("R8 held without load", dac_code, 12'h73E);
        load_pulse();
        check("R8 copied on rise", dac_code, 12'h111);
    endtask

    task automatic t_transparent_write();
        ld_n = 1'b0; cs_lo_n = 1'b0; cs_hi_n = 1'b0;
        d_lo = 8'h22; d_hi = 4'h2; step(1); wr_n = 1'b0; step(6);
        check("R5 follows first", dac_code, 12'h222);
        d_lo = 8'h33; d_hi = 4'h3; step(6);
        check("R5 follows change", dac_code, 12'h333);
        wr_n = 1'b1; step(4);
        d_lo = 8'h44; d_hi = 4'h4; step(6);
        check("R6 held after rise", dac_code, 12'h333);
        cs_lo_n = 1'b1; cs_hi_n = 1'b1; ld_n = 1'b1; step(4);
    endtask

    task automatic t_transparent_load();
        ld_n = 1'b0; step(4);
        bus_write(8'hA5, 4'h5, 1, 1); step(2);
        check("R9 ld low transparent", dac_code, 12'h5A5);
        ld_n = 1'b1; step(4);
    endtask

    task automatic t_mux8();
        bus_write(8'hC8, 4'h8, 1, 0);
        bus_write(8'h0B, 4'hB, 0, 1);
        load_pulse();
        check("R13 8-bit bus", dac_code, 12'hBC8);
    endtask

    task automatic t_clear();
        @(negedge clk); #1 clr_n = 1'b0; #1;
        check("R1 async clear", dac_code, 12'h000);
        d_lo = 8'hFF; d_hi = 4'hF; cs_lo_n = 1'b0; cs_hi_n = 1'b0;
        wr_n = 1'b0; ld_n = 1'b0; step(6);
        check("R10 clear dominates", dac_code, 12'h000);
        wr_n = 1'b1; ld_n = 1'b1; cs_lo_n = 1'b1; cs_hi_n = 1'b1; step(2);
        clr_n = 1'b1; step(4);
        load_pulse();
        check("R10 zero after release", dac_code, 12'h000);
        bus_write(8'hFF, 4'hF, 1, 1); load_pulse();
        check("R11 top code tap", tap_idx, 12'hFFF);
    endtask

    initial begin
        t_reset();
        t_full_word();
        t_sections();
        t_load_gate();
        t_transparent_write();
        t_transparent_load();
        t_mux8();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule